// File: doc/BRIEF.md
# Low-Address Access Trap

This block sits on a Wishbone-style bus between the CPU master and the boot flash slave. It watches every bus cycle for an address inside a small region that starts at address zero. A stray dereference through a null or nearly-null pointer lands in that region. The block answers such a cycle with a bus error, and the CPU then takes a data bus error exception that software can catch and report. All other cycles reach the flash slave untouched.

The trapped region is a power of two in bytes, anchored at zero. Matching it only means testing that the address bits at and above log2 of the size are all zero, so the comparator stays a narrow NOR of the top bits. Reads inside the region are held back from the flash. The block answers them itself with a one-cycle error. Writes inside the region still go to the flash, so the flash sees that one write. The error is then raised in the same cycle as the flash acknowledge. That means acknowledge and error can be high together.

Top module: `null_trap_guard`

## Requirements
- R1: An access is inside the trapped region when every address bit at or above log2(WIN_BYTES) is zero. With the default WIN_BYTES = 524288, byte address 0x0007_FFFF is inside and 0x0008_0000 is outside.
- R2: For every cycle that is not a read inside the region, the slave-side cyc, stb, we, adr, sel and write data equal the master-side ones. m_ack equals s_ack, and m_err stays low unless R4 applies.
- R3: During a read inside the region (m_cyc=1, m_stb=1, m_we=0), s_cyc and s_stb are held at 0 and m_ack stays 0 whatever s_ack does. m_err is 0 in the first cycle of the request and 1 in the cycle after the following rising clock edge.
- R4: A write inside the region (m_we=1) is forwarded to the slave. In any cycle where s_ack is 1 for that write, m_err and m_ack are both 1.
- R5: m_err is 1 only while m_cyc and m_stb are both 1 and the address is inside the region.
- R6: While rst_n is low at a rising edge, the read error pulse is cleared, so m_err is 0 afterwards until a new in-region read is seen.
- R7: A read error lasts one cycle. If the master keeps the same in-region read asserted, m_err goes 0, 1, 0, 1 on successive cycles.
- R8: m_dat_r always equals s_dat_r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_cyc | input | 1 | Master cycle valid |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | AW | Master byte address |
| m_sel | input | DW/8 | Master byte lane selects |
| m_dat_w | input | DW | Master write data |
| m_dat_r | output | DW | Read data returned to master |
| m_ack | output | 1 | Acknowledge to master |
| m_err | output | 1 | Bus error to master |
| s_cyc | output | 1 | Cycle valid toward flash slave |
| s_stb | output | 1 | Strobe toward flash slave |
| s_we | output | 1 | Write enable toward flash slave |
| s_adr | output | AW | Address toward flash slave |
| s_sel | output | DW/8 | Byte lane selects toward flash slave |
| s_dat_w | output | DW | Write data toward flash slave |
| s_dat_r | input | DW | Read data from flash slave |
| s_ack | input | 1 | Acknowledge from flash slave |

## Verification
The vector table runs reads and writes on both sides of the region edge. It includes the last in-region byte, the first out-of-region byte, address zero and the top of the address space. This separates a comparator that is off by one bit from a correct one. Each direction is tried with the slave acknowledge both high and low. A guard that blocks writes, or that lets reads through, shows up as a wrong slave strobe. A guard that leaves out the simultaneous error, or that wrongly hides the acknowledge, shows up at m_ack and m_err. Cycles with strobe or cycle missing confirm that no error appears without a full request. Directed sequences then hold an in-region read for several cycles to check the pulse timing, and apply reset while a pulse is pending.

// File: rtl/null_trap_pkg.sv
// Shared types for the low-address trap.
// Assumes nothing beyond a single bus clock domain.
package null_trap_pkg;
    // Classification of the current master request.
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_PASS   = 2'd1,
        REQ_RD_HIT = 2'd2,
        REQ_WR_HIT = 2'd3
    } req_kind_e;
endpackage

// File: rtl/null_trap_window.sv
// Region match for a power-of-two window anchored at address zero.
// Assumes WIN_BYTES is a power of two. Only the bits above log2(WIN_BYTES)
// are compared.
module null_trap_window #(
    parameter int AW        = 32,
    parameter int WIN_BYTES = 524288
) (
    input  logic [AW-1:0] adr,
    output logic          in_win
);
    localparam int WIN_LOG = $clog2(WIN_BYTES);

    initial assert (WIN_BYTES == (1 << WIN_LOG))
        else $error("WIN_BYTES must be a power of two");

    generate
        if (WIN_LOG >= AW) begin : g_all
            // Region covers the whole address space.
            always_comb in_win = 1'b1;
        end else begin : g_upper
            // Inside when every upper bit is zero.
            always_comb in_win = ~|adr[AW-1:WIN_LOG];
        end
    endgenerate
endmodule

// File: rtl/null_trap_rd_err.sv
// Error responder for trapped reads: produces a one-cycle error pulse,
// registered, after an in-region read request. Assumes the master holds
// its request until it sees a response.
module null_trap_rd_err (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    output logic err_q
);
    // Raise the pulse one cycle after a request, then drop it.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= rd_hit & ~err_q;
    end

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);
    assert_pulse_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !err_q) |=> err_q);
endmodule

// File: rtl/null_trap_guard.sv
// Low-address trap between a bus master and the boot flash slave.
// In-region reads are blocked and answered with an error. In-region writes
// reach the slave and get an error together with the slave acknowledge.
// Assumes a byte address on m_adr and a slave that acknowledges with s_ack.
module null_trap_guard #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int WIN_BYTES = 524288
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            m_cyc,
    input  logic            m_stb,
    input  logic            m_we,
    input  logic [AW-1:0]   m_adr,
    input  logic [DW/8-1:0] m_sel,
    input  logic [DW-1:0]   m_dat_w,
    output logic [DW-1:0]   m_dat_r,
    output logic            m_ack,
    output logic            m_err,
    output logic            s_cyc,
    output logic            s_stb,
    output logic            s_we,
    output logic [AW-1:0]   s_adr,
    output logic [DW/8-1:0] s_sel,
    output logic [DW-1:0]   s_dat_w,
    input  logic [DW-1:0]   s_dat_r,
    input  logic            s_ack
);
    import null_trap_pkg::*;

    logic      in_win;
    logic      rd_hit;
    logic      wr_hit;
    logic      err_q;
    req_kind_e kind;

    null_trap_window #(.AW(AW), .WIN_BYTES(WIN_BYTES)) u_window (
        .adr    (m_adr),
        .in_win (in_win)
    );

    // Classify the present master request.
    always_comb begin
        if (!(m_cyc && m_stb)) kind = REQ_NONE;
        else if (!in_win)      kind = REQ_PASS;
        else if (m_we)         kind = REQ_WR_HIT;
        else                   kind = REQ_RD_HIT;
    end

    assign rd_hit = (kind == REQ_RD_HIT);
    assign wr_hit = (kind == REQ_WR_HIT);

    null_trap_rd_err u_rd_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_hit),
        .err_q  (err_q)
    );

    // Forward the request to the slave unless it is a trapped read.
    always_comb begin
        s_cyc   = m_cyc & ~rd_hit;
        s_stb   = m_stb & ~rd_hit;
        s_we    = m_we;
        s_adr   = m_adr;
        s_sel   = m_sel;
        s_dat_w = m_dat_w;
    end

    // Build the master response from slave and local error sources.
    always_comb begin
        m_dat_r = s_dat_r;
        m_ack   = s_ack & ~rd_hit;
        m_err   = (err_q & rd_hit) | (wr_hit & s_ack);
    end

    assert_rd_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (!s_stb && !s_cyc && !m_ack));
    assert_wr_err_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && s_ack) |-> (m_err && m_ack && s_stb));
    assert_err_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> (m_cyc && m_stb && in_win));
    assert_pass_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && m_stb && !in_win) |-> (!m_err && m_ack == s_ack && s_stb));
endmodule

// File: tb/null_trap_guard_tb.sv
module null_trap_guard_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic          cyc;
        logic          stb;
        logic          we;
        logic [31:0]   adr;
        logic          sack;
        logic [31:0]   sdat;
        logic          x_sstb;
        logic          x_ack;
        logic          x_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,32'h0008_0000,1'b1,32'hA5A5_0001,1'b1,1'b1,1'b0}, // R1 first outside
        '{1'b1,1'b1,1'b0,32'hFFFF_FFFC,1'b0,32'h0000_1234,1'b1,1'b0,1'b0}, // R2 top
        '{1'b1,1'b1,1'b1,32'h1000_0000,1'b1,32'h5A5A_0002,1'b1,1'b1,1'b0}, // R2 write
        '{1'b1,1'b1,1'b0,32'h0000_0000,1'b1,32'h0BAD_0003,1'b0,1'b0,1'b0}, // R3 zero
        '{1'b1,1'b1,1'b0,32'h0007_FFFC,1'b0,32'h0000_0004,1'b0,1'b0,1'b0}, // R1 R3 last
        '{1'b1,1'b1,1'b1,32'h0000_0004,1'b0,32'h0000_0005,1'b1,1'b0,1'b0}, // R4 no ack
        '{1'b1,1'b1,1'b1,32'h0007_FFFF,1'b1,32'h0000_0006,1'b1,1'b1,1'b1}, // R4 R1 edge
        '{1'b1,1'b1,1'b1,32'h0000_0000,1'b1,32'h0000_0007,1'b1,1'b1,1'b1}, // R4 zero
        '{1'b1,1'b0,1'b1,32'h0000_0000,1'b1,32'h0000_0008,1'b0,1'b1,1'b0}, // R5 no stb
        '{1'b0,1'b1,1'b0,32'h0000_0000,1'b0,32'h0000_0009,1'b1,1'b0,1'b0}  // R5 no cyc
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_cyc = 1'b0, m_stb = 1'b0, m_we = 1'b0;
    logic [AW-1:0] m_adr = '0;
    logic [3:0]    m_sel = 4'hF;
    logic [DW-1:0] m_dat_w = 32'hCAFE_F00D;
    logic [DW-1:0] m_dat_r;
    logic          m_ack, m_err;
    logic          s_cyc, s_stb, s_we;
    logic [AW-1:0] s_adr;
    logic [3:0]    s_sel;
    logic [DW-1:0] s_dat_w;
    logic [DW-1:0] s_dat_r = '0;
    logic          s_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    null_trap_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
        .m_sel(m_sel), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r),
        .m_ack(m_ack), .m_err(m_err),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_sel(s_sel), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_ack(s_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0; s_ack = 1'b0;
    endtask

    initial begin
        // Reset state
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 err after reset", {63'd0, m_err}, 64'd0);
        chk("R6 ack after reset", {63'd0, m_ack}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            m_cyc = TBL[i].cyc; m_stb = TBL[i].stb; m_we = TBL[i].we;
            m_adr = TBL[i].adr; s_ack = TBL[i].sack; s_dat_r = TBL[i].sdat;
            #1;
            chk("R2 R3 s_stb", {63'd0, s_stb}, {63'd0, TBL[i].x_sstb});
            chk("R2 R3 R4 m_ack", {63'd0, m_ack}, {63'd0, TBL[i].x_ack});
            chk("R4 R5 m_err", {63'd0, m_err}, {63'd0, TBL[i].x_err});
            chk("R8 m_dat_r", {32'd0, m_dat_r}, {32'd0, TBL[i].sdat});
            if (TBL[i].x_sstb) begin
                chk("R2 s_adr", {32'd0, s_adr}, {32'd0, TBL[i].adr});
                chk("R2 s_we", {63'd0, s_we}, {63'd0, TBL[i].we});
                chk("R2 s_dat_w", {32'd0, s_dat_w}, {32'd0, m_dat_w});
            end
            @(negedge clk);
            idle();
            @(negedge clk);
        end

        // R7 / R3: held in-region read pulses every other cycle
        m_cyc = 1'b1; m_stb = 1'b1; m_we = 1'b0; m_adr = 32'h0000_0010; s_ack = 1'b1;
        #1;
        chk("R3 err first cycle", {63'd0, m_err}, 64'd0);
        chk("R3 s_cyc blocked", {63'd0, s_cyc}, 64'd0);
        @(negedge clk);
        chk("R3 err after edge", {63'd0, m_err}, 64'd1);
        chk("R3 ack low on trap", {63'd0, m_ack}, 64'd0);
        @(negedge clk);
        chk("R7 err drops", {63'd0, m_err}, 64'd0);
        @(negedge clk);
        chk("R7 err again", {63'd0, m_err}, 64'd1);

        // R6: reset while pulse pending
        @(negedge clk);      // err low here, pulse pending next
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 reset clears pulse", {63'd0, m_err}, 64'd0);
        rst_n = 1'b1;
        idle();
        @(negedge clk);
        @(negedge clk);
        chk("R5 idle no err", {63'd0, m_err}, 64'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule